// File: doc/BRIEF.md
# Programmable Chip-Select and Ready Generator

This block turns each bus cycle's address into one of thirteen active-low device selects and paces the cycle with a ready signal. It decodes a 20-bit address, qualified by a memory/IO indicator and a one-cycle start strobe. The selects cover four kinds of region:

- one region at the top of the 1 Mbyte space;
- one region at the bottom of the space;
- a relocatable middle block cut into four equal quarters;
- seven consecutive 128-byte peripheral windows above a programmable base.

Software places and sizes the regions through a small write port. Every region group carries its own wait-state count (0 to 3) and its own choice to honour or ignore the external ready input. The select picked at the strobe is registered. It stays low from the cycle after the strobe until the cycle after `rdy_out` goes high. While a selected cycle runs, `rdy_out` stays low until the programmed number of waits has elapsed and, if the region honours it, until `ext_rdy` is high. Cycles that hit no region pass `ext_rdy` straight to `rdy_out`.

Configuration registers, addressed by `cfg_addr`. In every register, bits [2:0] are the ready field: bits [1:0] hold the wait count and bit 2 set means external ready is ignored.

| `cfg_addr` | Region | Fields |
|---|---|---|
| 0 | Upper | bits [15:6] are address bits 19..10 of the region start; the region runs to 0xFFFFF |
| 1 | Lower | bits [15:6] are address bits 19..10 of the last 1K page; the region starts at 0x00000 |
| 2 | Middle block base | bits [15:9] are address bits 19..13 |
| 3 | Middle block control | bits [5:3] hold the size code k, giving a block of 8K<<k bytes |
| 4 | Peripheral | bits [15:6] are address bits 19..10 of the base; bit 5 set picks IO space |

Top module: `chip_sel_ready`

## Requirements
- R1: While `rst_n` is low, every select output is high. With no selected cycle in progress, `rdy_out` equals `ext_rdy`.
- R2: After reset, the upper register holds 0xFFFB. Memory addresses 0xFFC00 to 0xFFFFF then assert `top_sel_n` with 3 waits, and external ready is honoured. Address 0xFFBFF selects nothing.
- R3: After reset, the lower, middle and peripheral regions select nothing. The middle block starts to decode only after a write to its control register (address 3).
- R4: Once the lower register is written, memory addresses from 0x00000 through the end of the programmed last 1K page assert `bot_sel_n`. The next address selects nothing.
- R5: A memory address inside the middle block asserts `mid_sel_n[q]`, where q is the quarter of the block holding the address. The lowest quarter gives q=0. Addresses past the block end select nothing.
- R6: Where the middle block overlaps the upper or lower region, the upper or lower select wins, and no middle select is asserted.
- R7: Window i, at offset i*128 to i*128+127 above the peripheral base, asserts `per_sel_n[i]` for i in 0..6. Offset 896 and above selects nothing.
- R8: Peripheral selects decode only in the space that bit 5 of the peripheral register picks (1 = IO). The upper, lower and middle regions decode only memory cycles (`bus_io`=0).
- R9: With `ext_rdy` high, a selected cycle whose region has a wait count of N keeps `rdy_out` low for exactly N cycles after the strobe, then drives it high.
- R10: If bit 2 of a region's ready field is 0, `rdy_out` also stays low while `ext_rdy` is low. If bit 2 is 1, `ext_rdy` has no effect on the cycle.
- R11: A select goes low in the cycle after the strobe and stays low until `rdy_out` is high. In the following cycle every select is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| bus_stb | input | 1 | One-cycle start of a bus cycle; address and space valid |
| bus_addr | input | 20 | Bus address |
| bus_io | input | 1 | 1 = IO space, 0 = memory space |
| ext_rdy | input | 1 | External ready |
| top_sel_n | output | 1 | Upper memory select, active low |
| bot_sel_n | output | 1 | Lower memory select, active low |
| mid_sel_n | output | 4 | Middle block quarter selects, active low |
| per_sel_n | output | 7 | Peripheral window selects, active low |
| rdy_out | output | 1 | Ready to the bus sequencer |

## Verification
A wrong configuration field or a bad decode comparison shows up in the cycle after the strobe as the wrong select line, or as no line at all. The directed cycles therefore sit on both sides of every region edge. A wrong wait counter or ready qualifier shows up as a wait-cycle count off by one or more at the first sample where `rdy_out` is expected. Each cycle is timed against an `ext_rdy` held low for a chosen number of cycles. A stuck activity flag shows up one cycle after ready as a select that never releases.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int REG_W     = 16;
    localparam int WAIT_W    = 2;
    localparam int RDY_FLD_W = WAIT_W + 1;
    localparam int SPACE_BIT = 5;
    localparam int MSIZE_LO  = 3;
    localparam int MSIZE_W   = 3;

    typedef struct packed {
        logic              ign_ext;
        logic [WAIT_W-1:0] waits;
    } rdy_cfg_t;

    typedef struct packed {
        logic             up_en;
        logic [REG_W-1:0] up;
        logic             lo_en;
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] mbase;
        logic             mid_en;
        logic [REG_W-1:0] mctl;
        logic             per_en;
        logic [REG_W-1:0] per;
    } cfg_t;

    localparam logic [REG_W-1:0] UP_RESET = 16'hFFFB;

    typedef enum logic [2:0] {
        REG_UP    = 3'd0,
        REG_LO    = 3'd1,
        REG_MBASE = 3'd2,
        REG_MCTL  = 3'd3,
        REG_PER   = 3'd4
    } reg_idx_e;

endpackage

// File: rtl/csr_cfg.sv
module csr_cfg
    import csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (reg_idx_e'(addr))
                REG_UP: begin
                    cfg_d.up    = wdata;
                    cfg_d.up_en = 1'b1;
                end
                REG_LO: begin
                    cfg_d.lo    = wdata;
                    cfg_d.lo_en = 1'b1;
                end
                REG_MBASE: cfg_d.mbase = wdata;
                REG_MCTL: begin
                    cfg_d.mctl   = wdata;
                    cfg_d.mid_en = 1'b1;
                end
                REG_PER: begin
                    cfg_d.per    = wdata;
                    cfg_d.per_en = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.up    <= UP_RESET;
            cfg_q.up_en <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R3: enables only rise through a write
    a_r3_enable_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.mid_en && !we) |=> !cfg_q.mid_en);

endmodule

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int UP_GRAN_LOG  = 10,
    parameter int MID_GRAN_LOG = 13,
    parameter int N_MID        = 4,
    parameter int N_PER        = 7,
    parameter int PER_WIN_LOG  = 7,
    localparam int NSEL        = 2 + N_MID + N_PER
)(
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    output logic [NSEL-1:0]   sel,
    output rdy_cfg_t          rc
);

    localparam int UP_FW     = ADDR_W - UP_GRAN_LOG;
    localparam int MID_FW    = ADDR_W - MID_GRAN_LOG;
    localparam int MID_IDX_W = $clog2(N_MID);
    localparam int PER_IDX_W = $clog2(N_PER);
    localparam logic [ADDR_W-1:0] PER_SPAN = ADDR_W'(N_PER << PER_WIN_LOG);

    logic                  up_hit, lo_hit, mid_hit, per_hit;
    logic [ADDR_W-1:0]     mbase, pbase, poff;
    logic [ADDR_W:0]       moff, msize;
    logic [MSIZE_W-1:0]    mk;
    logic [MID_IDX_W-1:0]  mq;
    logic [PER_IDX_W-1:0]  pidx;

    always_comb begin
        up_hit = cfg.up_en && !bus_io &&
                 (bus_addr[ADDR_W-1:UP_GRAN_LOG] >= cfg.up[REG_W-1 -: UP_FW]);
        lo_hit = cfg.lo_en && !bus_io && !up_hit &&
                 (bus_addr[ADDR_W-1:UP_GRAN_LOG] <= cfg.lo[REG_W-1 -: UP_FW]);

        mk      = cfg.mctl[MSIZE_LO +: MSIZE_W];
        mbase   = {cfg.mbase[REG_W-1 -: MID_FW], {MID_GRAN_LOG{1'b0}}};
        msize   = (ADDR_W+1)'(1) << (MID_GRAN_LOG + int'(mk));
        moff    = {1'b0, bus_addr} - {1'b0, mbase};
        mid_hit = cfg.mid_en && !bus_io && !up_hit && !lo_hit &&
                  (bus_addr >= mbase) && (moff < msize);
        mq      = MID_IDX_W'(moff >> (MID_GRAN_LOG + int'(mk) - MID_IDX_W));

        pbase   = {cfg.per[REG_W-1 -: UP_FW], {UP_GRAN_LOG{1'b0}}};
        poff    = bus_addr - pbase;
        per_hit = cfg.per_en && (bus_io == cfg.per[SPACE_BIT]) &&
                  !up_hit && !lo_hit && !mid_hit &&
                  (bus_addr >= pbase) && (poff < PER_SPAN);
        pidx    = poff[PER_WIN_LOG +: PER_IDX_W];

        if (up_hit)       rc = rdy_cfg_t'(cfg.up[RDY_FLD_W-1:0]);
        else if (lo_hit)  rc = rdy_cfg_t'(cfg.lo[RDY_FLD_W-1:0]);
        else if (mid_hit) rc = rdy_cfg_t'(cfg.mctl[RDY_FLD_W-1:0]);
        else if (per_hit) rc = rdy_cfg_t'(cfg.per[RDY_FLD_W-1:0]);
        else              rc = '0;
    end

    assign sel[0] = up_hit;
    assign sel[1] = lo_hit;

    for (genvar g = 0; g < N_MID; g++) begin : g_mid
        assign sel[2+g] = mid_hit && (mq == MID_IDX_W'(g));
    end

    for (genvar g = 0; g < N_PER; g++) begin : g_per
        assign sel[2+N_MID+g] = per_hit && (pidx == PER_IDX_W'(g));
    end

endmodule

// File: rtl/csr_waitgen.sv
module csr_waitgen
    import csr_pkg::*;
#(
    parameter int NSEL = 13
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic [NSEL-1:0] sel_in,
    input  rdy_cfg_t        rc_in,
    input  logic            ext_rdy,
    output logic [NSEL-1:0] sel,
    output logic            rdy
);

    typedef struct packed {
        logic              act;
        logic [WAIT_W-1:0] cnt;
        rdy_cfg_t          rc;
        logic [NSEL-1:0]   sel;
    } st_t;

    st_t  st_d, st_q;
    logic int_rdy;

    always_comb begin
        st_d    = st_q;
        int_rdy = st_q.cnt >= st_q.rc.waits;
        rdy     = st_q.act ? (int_rdy && (st_q.rc.ign_ext || ext_rdy)) : ext_rdy;
        if (st_q.act) begin
            if (rdy)           st_d = '0;
            else if (!int_rdy) st_d.cnt = st_q.cnt + 1'b1;
        end else if (stb && (|sel_in)) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
            st_d.rc  = rc_in;
            st_d.sel = sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;

    // R1: selects idle under reset
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (st_q.sel == '0));
    // R11: at most one select
    a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.sel));
    // R11: release after ready
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && rdy) |=> (st_q.sel == '0));
    // R9: no ready before waits elapse
    a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && (st_q.cnt < st_q.rc.waits)) |-> !rdy);
    // R10: honoured external ready gates completion
    a_r10_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !st_q.rc.ign_ext && !ext_rdy) |-> !rdy);
    // R9: counter never passes the wait count
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> (st_q.cnt <= st_q.rc.waits));

endmodule

// File: rtl/chip_sel_ready.sv
module chip_sel_ready
    import csr_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int UP_GRAN_LOG  = 10,
    parameter int MID_GRAN_LOG = 13,
    parameter int N_MID        = 4,
    parameter int N_PER        = 7,
    parameter int PER_WIN_LOG  = 7
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              bus_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    input  logic              ext_rdy,
    output logic              top_sel_n,
    output logic              bot_sel_n,
    output logic [N_MID-1:0]  mid_sel_n,
    output logic [N_PER-1:0]  per_sel_n,
    output logic              rdy_out
);

    localparam int NSEL = 2 + N_MID + N_PER;

    cfg_t            cfg;
    logic [NSEL-1:0] dec_sel, sel_q;
    rdy_cfg_t        dec_rc;

    csr_cfg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    csr_decode #(
        .ADDR_W       (ADDR_W),
        .UP_GRAN_LOG  (UP_GRAN_LOG),
        .MID_GRAN_LOG (MID_GRAN_LOG),
        .N_MID        (N_MID),
        .N_PER        (N_PER),
        .PER_WIN_LOG  (PER_WIN_LOG)
    ) i_decode (
        .cfg      (cfg),
        .bus_addr (bus_addr),
        .bus_io   (bus_io),
        .sel      (dec_sel),
        .rc       (dec_rc)
    );

    csr_waitgen #(.NSEL(NSEL)) i_waitgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (bus_stb),
        .sel_in  (dec_sel),
        .rc_in   (dec_rc),
        .ext_rdy (ext_rdy),
        .sel     (sel_q),
        .rdy     (rdy_out)
    );

    assign top_sel_n = ~sel_q[0];
    assign bot_sel_n = ~sel_q[1];
    assign mid_sel_n = ~sel_q[2 +: N_MID];
    assign per_sel_n = ~sel_q[2+N_MID +: N_PER];

    // R6: upper/lower win over the middle block
    a_r6_mid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_sel[0] || dec_sel[1]) |-> (dec_sel[2 +: N_MID] == '0));
    // R8: IO cycles never hit memory-only regions
    a_r8_io_space: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io |-> (dec_sel[2+N_MID-1:0] == '0));

endmodule

// File: tb/test_chip_sel_ready.sv
module test_chip_sel_ready;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_stb = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_io = 1'b0;
    logic        ext_rdy = 1'b1;
    logic        top_sel_n, bot_sel_n, rdy_out;
    logic [3:0]  mid_sel_n;
    logic [6:0]  per_sel_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    chip_sel_ready i_chip_sel_ready (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_stb(bus_stb), .bus_addr(bus_addr),
        .bus_io(bus_io), .ext_rdy(ext_rdy), .top_sel_n(top_sel_n),
        .bot_sel_n(bot_sel_n), .mid_sel_n(mid_sel_n), .per_sel_n(per_sel_n),
        .rdy_out(rdy_out)
    );

    function automatic logic [12:0] active_sel();
        return {~per_sel_n, ~mid_sel_n, ~bot_sel_n, ~top_sel_n};
    endfunction

    task automatic check(string req, bit ok, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // idx: 0 upper, 1 lower, 2..5 middle quarters, 6..12 peripheral windows, -1 none
    task automatic run_cycle(string req, logic [19:0] a, logic io, int idx,
                             int exp_waits, int dly);
        logic [12:0] exp_sel;
        int k;
        exp_sel = (idx < 0) ? 13'd0 : (13'd1 << idx);
        @(negedge clk);
        bus_stb = 1'b1; bus_addr = a; bus_io = io;
        @(negedge clk);
        bus_stb = 1'b0;
        k = 0;
        forever begin
            ext_rdy = (k >= dly);
            #1;
            if (k == 0) check({req, " select"}, active_sel() == exp_sel,
                              active_sel(), exp_sel);
            if (rdy_out || k > 20) break;
            k++;
            @(negedge clk);
        end
        check({req, " waits"}, k == exp_waits, k, exp_waits);
        @(negedge clk);
        #1;
        check({req, " R11 release"}, active_sel() == 13'd0, active_sel(), 0);
        ext_rdy = 1'b1;
    endtask

    task automatic t_reset();
        #1;
        check("R1 selects high in reset", active_sel() == 13'd0, active_sel(), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ext_rdy = 1'b0; #1;
        check("R1 idle passthrough low", rdy_out == 1'b0, rdy_out, 0);
        ext_rdy = 1'b1; #1;
        check("R1 idle passthrough high", rdy_out == 1'b1, rdy_out, 1);
    endtask

    task automatic t_upper_default();
        run_cycle("R2 R9 upper start", 20'hFFC00, 1'b0, 0, 3, 0);
        run_cycle("R2 upper top", 20'hFFFFF, 1'b0, 0, 3, 0);
        run_cycle("R2 R10 upper ext honoured", 20'hFFC10, 1'b0, 0, 5, 5);
        run_cycle("R2 below upper", 20'hFFBFF, 1'b0, -1, 0, 0);
        run_cycle("R8 upper in IO space", 20'hFFC00, 1'b1, -1, 2, 2);
    endtask

    task automatic t_unprogrammed();
        run_cycle("R3 lower inactive", 20'h00000, 1'b0, -1, 0, 0);
        run_cycle("R3 middle inactive", 20'h80000, 1'b0, -1, 1, 1);
    endtask

    task automatic t_lower();
        write_cfg(3'd1, 16'h03C5); // last page 0x00F, 1 wait, ignore ext
        run_cycle("R4 lower base", 20'h00000, 1'b0, 1, 1, 0);
        run_cycle("R4 R10 lower end ignore ext", 20'h03FFF, 1'b0, 1, 1, 6);
        run_cycle("R4 past lower", 20'h04000, 1'b0, -1, 0, 0);
    endtask

    task automatic t_middle();
        write_cfg(3'd2, 16'h2000); // base 0x20000
        run_cycle("R3 middle before control", 20'h20000, 1'b0, -1, 0, 0);
        write_cfg(3'd3, 16'h0012); // k=2 -> 32K, 2 waits, honour ext
        run_cycle("R5 quarter0", 20'h20000, 1'b0, 2, 2, 0);
        run_cycle("R5 quarter1", 20'h22000, 1'b0, 3, 2, 0);
        run_cycle("R5 quarter2", 20'h25FFF, 1'b0, 4, 2, 0);
        run_cycle("R5 R10 quarter3 ext", 20'h27FFF, 1'b0, 5, 4, 4);
        run_cycle("R5 past middle", 20'h28000, 1'b0, -1, 0, 0);
        run_cycle("R5 below middle", 20'h1FFFF, 1'b0, -1, 0, 0);
        run_cycle("R8 middle in IO", 20'h20000, 1'b1, -1, 0, 0);
    endtask

    task automatic t_periph();
        write_cfg(3'd4, 16'h0064); // base 0x400, IO space, 0 waits, ignore ext
        run_cycle("R7 window0", 20'h00400, 1'b1, 6, 0, 3);
        run_cycle("R7 window3", 20'h005A0, 1'b1, 9, 0, 0);
        run_cycle("R7 window6", 20'h0077F, 1'b1, 12, 0, 0);
        run_cycle("R7 past windows", 20'h00780, 1'b1, -1, 0, 0);
        run_cycle("R7 below base", 20'h003FF, 1'b1, -1, 0, 0);
        run_cycle("R8 periph wrong space", 20'h10400, 1'b0, -1, 0, 0);
        write_cfg(3'd4, 16'h4002); // base 0x40000, memory space, 2 waits
        run_cycle("R8 periph memory window1", 20'h40080, 1'b0, 7, 2, 0);
        run_cycle("R8 periph memory not IO", 20'h40080, 1'b1, -1, 0, 0);
    endtask

    task automatic t_overlap();
        write_cfg(3'd2, 16'h0000); // middle base 0
        write_cfg(3'd3, 16'h0002); // 8K, 2 waits
        run_cycle("R6 lower wins over middle", 20'h01000, 1'b0, 1, 1, 0);
        write_cfg(3'd2, 16'hFE00); // middle base 0xFE000, overlaps upper
        run_cycle("R6 upper wins over middle", 20'hFFC00, 1'b0, 0, 3, 0);
        run_cycle("R6 middle below upper", 20'hFE000, 1'b0, 2, 2, 0);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_cycle("R3 lower cleared by reset", 20'h00000, 1'b0, -1, 0, 0);
        run_cycle("R2 upper restored", 20'hFFC00, 1'b0, 0, 3, 0);
    endtask

    initial begin
        t_reset();
        t_upper_default();
        t_unprogrammed();
        t_lower();
        t_middle();
        t_periph();
        t_overlap();
        t_reset_again();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule